// File: doc/BRIEF.md
# Flash Write Completion Poller

This block sits on the host side of a parallel flash and decides when a program or erase that has already been launched inside the flash is finished. The host gives it a one-cycle start pulse with the operation kind, the word address that was written or erased, and for a program the data that was written. The poller then reads that address again and again through a request/response read port and inspects one status bit of each returned word.

Two status methods are available, chosen per operation by a mode input. Data polling looks at bit 7: during a program it reads as the complement of the written bit, and during an erase it reads 0 until the erase ends. Toggle checking looks at bit 6, which alternates on every read while the flash is busy and holds still once it is idle. The flash finishes at a time the host cannot see, so one read that looks finished is not enough. A read that shows completion is always followed by one more read of the same word, and only a second read that also shows completion ends the poll. A bounded number of reads ends a stuck poll with an error pulse.

Both read channels use valid/ready. A request, once raised, stays raised with a stable address until the responder takes it. Only one read is outstanding at a time. The poller is always ready for the response while it waits for one, and it never holds a response back. Start, done, error and busy are plain level or pulse pins.

Top module: `fwp_poller`

## Requirements
- R1: After reset, and whenever no operation is running, busy, done, error, read-request valid and response ready are all 0.
- R2: A start pulse is taken only when busy is 0. Busy is 1 in the cycle after it. A start pulse while busy changes nothing: no new address, operation kind or mode, and no change in the read count or the result.
- R3: Every read request carries the address latched at start. While valid is high and ready is low, valid stays high and the address is stable. A new request is raised only after the previous response is accepted.
- R4: With op_i = 0 (program) and mode_i = 0 (data polling), a read shows completion when its bit 7 equals bit 7 of the expected data.
- R5: With op_i = 1 (erase) and mode_i = 0, a read shows completion when its bit 7 is 1.
- R6: With mode_i = 1 (toggle checking), a read shows completion when its bit 6 equals bit 6 of the previous read of the same operation. The first read of an operation never shows completion.
- R7: Done is raised only when a read shows completion and the read just before it also showed completion. Done is high in the cycle after the edge that accepts that second response.
- R8: If the confirming read does not show completion, polling goes on with no error, and a completion pair is needed again.
- R9: If MAX_POLLS responses have been accepted without done, error is high in the cycle after the edge that accepts the last of them, and no further request is made.
- R10: Done and error are single-cycle pulses, never high together, and busy is 0 in the cycle where either one is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | One-cycle request to begin polling |
| op_i | input | 1 | Operation kind: 0 program, 1 erase |
| mode_i | input | 1 | Status method: 0 data polling (bit 7), 1 toggle checking (bit 6) |
| addr_i | input | ADDR_W | Address to poll |
| exp_data_i | input | DATA_W | Data written by the program |
| busy_o | output | 1 | An operation is being polled |
| done_o | output | 1 | Pulse: completion confirmed |
| err_o | output | 1 | Pulse: read limit reached without completion |
| rd_req_valid_o | output | 1 | Read request valid |
| rd_req_ready_i | input | 1 | Read request accepted by the responder |
| rd_req_addr_o | output | ADDR_W | Read request address |
| rd_rsp_valid_i | input | 1 | Read response valid |
| rd_rsp_ready_o | output | 1 | Poller can accept a response |
| rd_rsp_data_i | input | DATA_W | Read response word |

## Verification
An accepted start raises the request valid in the next cycle. The response to that request is accepted at the edge where both response signals are high. Done or error then shows in the cycle right after that edge, and busy drops in that same cycle. The bench drives and samples on falling edges. It keeps a one-cycle delayed record of the response handshake, so it can check that the pulse lines up with it. It counts accepted reads and compares the count with the number it expects from the point where the responder starts answering "finished". That number is reads-to-finish plus two for data polling and plus three for toggle checking, capped at the read limit.

// File: rtl/fwp_pkg.sv
package fwp_pkg;

  typedef enum logic {
    OP_PROGRAM = 1'b0,
    OP_ERASE   = 1'b1
  } flash_op_e;

  typedef enum logic {
    CHK_DATA   = 1'b0,
    CHK_TOGGLE = 1'b1
  } check_mode_e;

  typedef enum logic [1:0] {
    PORT_IDLE = 2'd0,
    PORT_REQ  = 2'd1,
    PORT_RSP  = 2'd2
  } port_state_e;

  typedef struct packed {
    flash_op_e   op;
    check_mode_e mode;
  } poll_cfg_t;

endpackage

// File: rtl/fwp_req_port.sv
module fwp_req_port
  import fwp_pkg::*;
#(
  parameter int unsigned ADDR_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              launch,
  input  logic [ADDR_W-1:0] addr,
  output logic              req_valid,
  input  logic              req_ready,
  output logic [ADDR_W-1:0] req_addr,
  input  logic              rsp_valid,
  output logic              rsp_ready,
  output logic              rsp_fire
);

  port_state_e st_q;

  assign req_valid = (st_q == PORT_REQ);
  assign rsp_ready = (st_q == PORT_RSP);
  assign rsp_fire  = rsp_ready && rsp_valid;
  assign req_addr  = addr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q <= PORT_IDLE;
    end else begin
      unique case (st_q)
        PORT_IDLE: if (launch) st_q <= PORT_REQ;
        PORT_REQ:  if (req_ready) st_q <= PORT_RSP;
        PORT_RSP:  if (rsp_valid) st_q <= launch ? PORT_REQ : PORT_IDLE;
        default:   st_q <= PORT_IDLE;
      endcase
    end
  end

  // R3: a request waiting on ready keeps its valid and address
  p_req_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_ready |=> req_valid && $stable(req_addr));

  // R3: the controller only launches when no read is in flight
  p_launch_legal_r3: assert property (@(posedge clk) disable iff (!rst_n)
    launch |-> (st_q == PORT_IDLE) || rsp_fire);

endmodule

// File: rtl/fwp_status_eval.sv
module fwp_status_eval
  import fwp_pkg::*;
#(
  parameter int unsigned DATA_W   = 16,
  parameter int unsigned POLL_BIT = 7,
  parameter int unsigned TOG_BIT  = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              sample,
  input  logic [DATA_W-1:0] data,
  input  poll_cfg_t         cfg,
  input  logic              exp_bit,
  output logic              complete
);

  logic have_prev_q;
  logic prev_tog_q;
  logic poll_bit;
  logic tog_bit;
  logic data_ok;
  logic tog_ok;

  assign poll_bit = data[POLL_BIT];
  assign tog_bit  = data[TOG_BIT];

  always_comb begin
    if (cfg.op == OP_PROGRAM) data_ok = (poll_bit == exp_bit);
    else                      data_ok = poll_bit;
  end

  assign tog_ok   = have_prev_q && (tog_bit == prev_tog_q);
  assign complete = (cfg.mode == CHK_TOGGLE) ? tog_ok : data_ok;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      have_prev_q <= 1'b0;
      prev_tog_q  <= 1'b0;
    end else if (clear) begin
      have_prev_q <= 1'b0;
    end else if (sample) begin
      have_prev_q <= 1'b1;
      prev_tog_q  <= tog_bit;
    end
  end

  logic unused_bits;
  assign unused_bits = ^{data};

endmodule

// File: rtl/fwp_poll_ctrl.sv
module fwp_poll_ctrl #(
  parameter int unsigned MAX_POLLS = 1024
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic rsp_fire,
  input  logic complete,
  output logic accept,
  output logic launch,
  output logic busy,
  output logic done,
  output logic err
);

  localparam int unsigned CNT_W = (MAX_POLLS > 1) ? $clog2(MAX_POLLS) : 1;
  localparam logic [CNT_W-1:0] LIMIT = CNT_W'(MAX_POLLS - 1);

  logic             busy_q;
  logic             conf_q;
  logic [CNT_W-1:0] cnt_q;
  logic             done_q;
  logic             err_q;
  logic             confirmed;
  logic             exhausted;

  assign accept    = start && !busy_q;
  assign confirmed = busy_q && rsp_fire && complete && conf_q;
  assign exhausted = busy_q && rsp_fire && !confirmed && (cnt_q == LIMIT);
  assign launch    = accept || (busy_q && rsp_fire && !confirmed && !exhausted);

  assign busy = busy_q;
  assign done = done_q;
  assign err  = err_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      conf_q <= 1'b0;
      cnt_q  <= '0;
      done_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
      if (accept) begin
        busy_q <= 1'b1;
        conf_q <= 1'b0;
        cnt_q  <= '0;
      end else if (confirmed) begin
        busy_q <= 1'b0;
        done_q <= 1'b1;
      end else if (exhausted) begin
        busy_q <= 1'b0;
        err_q  <= 1'b1;
      end else if (busy_q && rsp_fire) begin
        cnt_q  <= cnt_q + 1'b1;
        conf_q <= complete;
      end
    end
  end

  // R10: the two result pulses never overlap
  p_pulse_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> !err_q);

  // R10: done lasts one cycle
  p_done_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);

  // R7: done follows a completing response while a confirmation was pending
  p_done_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> $past(rsp_fire && complete && conf_q));

  // R9: the error follows the response that used up the read budget
  p_err_at_limit_r9: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |-> $past(rsp_fire && cnt_q == LIMIT));

  // R2: a start while busy leaves the read count alone
  p_start_ignored_r2: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q && start && !rsp_fire |=> busy_q && $stable(cnt_q));

endmodule

// File: rtl/fwp_poller.sv
module fwp_poller
  import fwp_pkg::*;
#(
  parameter int unsigned ADDR_W    = 24,
  parameter int unsigned DATA_W    = 16,
  parameter int unsigned MAX_POLLS = 1024,
  parameter int unsigned POLL_BIT  = 7,
  parameter int unsigned TOG_BIT   = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              op_i,
  input  logic              mode_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] exp_data_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              err_o,
  output logic              rd_req_valid_o,
  input  logic              rd_req_ready_i,
  output logic [ADDR_W-1:0] rd_req_addr_o,
  input  logic              rd_rsp_valid_i,
  output logic              rd_rsp_ready_o,
  input  logic [DATA_W-1:0] rd_rsp_data_i
);

  poll_cfg_t         cfg_q;
  logic [ADDR_W-1:0] addr_q;
  logic              exp_bit_q;
  logic              accept;
  logic              launch;
  logic              rsp_fire;
  logic              complete;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_q     <= '{op: OP_PROGRAM, mode: CHK_DATA};
      addr_q    <= '0;
      exp_bit_q <= 1'b0;
    end else if (accept) begin
      cfg_q.op   <= flash_op_e'(op_i);
      cfg_q.mode <= check_mode_e'(mode_i);
      addr_q     <= addr_i;
      exp_bit_q  <= exp_data_i[POLL_BIT];
    end
  end

  fwp_poll_ctrl #(
    .MAX_POLLS (MAX_POLLS)
  ) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start_i),
    .rsp_fire (rsp_fire),
    .complete (complete),
    .accept   (accept),
    .launch   (launch),
    .busy     (busy_o),
    .done     (done_o),
    .err      (err_o)
  );

  fwp_req_port #(
    .ADDR_W (ADDR_W)
  ) u_port (
    .clk       (clk),
    .rst_n     (rst_n),
    .launch    (launch),
    .addr      (addr_q),
    .req_valid (rd_req_valid_o),
    .req_ready (rd_req_ready_i),
    .req_addr  (rd_req_addr_o),
    .rsp_valid (rd_rsp_valid_i),
    .rsp_ready (rd_rsp_ready_o),
    .rsp_fire  (rsp_fire)
  );

  fwp_status_eval #(
    .DATA_W   (DATA_W),
    .POLL_BIT (POLL_BIT),
    .TOG_BIT  (TOG_BIT)
  ) u_eval (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (accept),
    .sample   (rsp_fire),
    .data     (rd_rsp_data_i),
    .cfg      (cfg_q),
    .exp_bit  (exp_bit_q),
    .complete (complete)
  );

  logic unused_exp;
  assign unused_exp = ^{exp_data_i};

  // R1: no read traffic while idle
  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> !rd_req_valid_o && !rd_rsp_ready_o);

  // R3: every request carries the latched address
  p_req_addr_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req_valid_o && busy_o && $past(busy_o) |-> $stable(addr_q));

  // R10: a result pulse coincides with idle
  p_pulse_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done_o || err_o |-> !busy_o);

endmodule

// File: tb/tb_fwp_poller.sv
module tb_fwp_poller;

  localparam int AW   = 16;
  localparam int DW   = 16;
  localparam int MAXP = 12;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic          rst_n = 1'b0;
  logic          start_i = 1'b0;
  logic          op_i = 1'b0;
  logic          mode_i = 1'b0;
  logic [AW-1:0] addr_i = '0;
  logic [DW-1:0] exp_i = '0;
  logic          busy_o, done_o, err_o;
  logic          rd_req_valid, rd_rsp_ready;
  logic [AW-1:0] rd_req_addr;
  logic          rd_req_ready = 1'b1;
  logic          rd_rsp_valid = 1'b0;
  logic [DW-1:0] rd_rsp_data = '0;

  fwp_poller #(
    .ADDR_W (AW), .DATA_W (DW), .MAX_POLLS (MAXP), .POLL_BIT (7), .TOG_BIT (6)
  ) dut (
    .clk (clk), .rst_n (rst_n), .start_i (start_i), .op_i (op_i), .mode_i (mode_i),
    .addr_i (addr_i), .exp_data_i (exp_i), .busy_o (busy_o), .done_o (done_o),
    .err_o (err_o), .rd_req_valid_o (rd_req_valid), .rd_req_ready_i (rd_req_ready),
    .rd_req_addr_o (rd_req_addr), .rd_rsp_valid_i (rd_rsp_valid),
    .rd_rsp_ready_o (rd_rsp_ready), .rd_rsp_data_i (rd_rsp_data)
  );

  int total = 0;
  int bad   = 0;

  logic          c_op = 1'b0, c_mode = 1'b0, c_bp = 1'b0;
  int            c_b = 0, c_g = -1, c_base = 0;
  logic [DW-1:0] c_exp = '0;
  logic [AW-1:0] c_addr = '0;

  int          n_req = 0;
  int          addr_bad = 0;
  logic        hs_d = 1'b0;
  logic [15:0] lfsr = 16'hace1;

  task automatic chk(input bit ok, input string tag, input int act, input int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  // Flash model: busy for c_b reads, finished afterwards; read c_g looks finished once.
  function automatic logic [DW-1:0] resp_word(int idx);
    logic [DW-1:0] d;
    logic fin;
    d = DW'(idx * 933 + 451);
    if (c_mode) begin
      d[6] = (idx < c_b) ? idx[0] : c_b[0];
    end else begin
      fin  = (idx >= c_b) || (idx == c_g);
      d[7] = c_op ? fin : (fin ? c_exp[7] : ~c_exp[7]);
      d[6] = idx[0];
    end
    return d;
  endfunction

  initial begin
    forever begin
      @(posedge clk);
      hs_d <= rd_rsp_valid && rd_rsp_ready;
      lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      rd_req_ready <= c_bp ? lfsr[0] : 1'b1;
      if (rd_rsp_valid && rd_rsp_ready) rd_rsp_valid <= 1'b0;
      if (rd_req_valid && rd_req_ready) begin
        if (rd_req_addr != c_addr) addr_bad <= addr_bad + 1;
        rd_rsp_valid <= 1'b1;
        rd_rsp_data  <= resp_word(n_req - c_base);
        n_req        <= n_req + 1;
      end
    end
  end

  task automatic run(input logic op, input logic mode, input int b, input int g,
                     input logic [DW-1:0] expd, input logic [AW-1:0] addr,
                     input logic bp, input bit restart, input string tag);
    int cyc, reads, need, exp_reads, abase;
    bit fin, exp_done;
    @(negedge clk);
    c_op = op; c_mode = mode; c_b = b; c_g = g; c_exp = expd; c_addr = addr;
    c_bp = bp; c_base = n_req; abase = addr_bad;
    start_i = 1'b1; op_i = op; mode_i = mode; addr_i = addr; exp_i = expd;
    @(negedge clk);
    start_i = 1'b0;
    chk(busy_o == 1'b1, "R2 busy after start", busy_o, 1);
    cyc = 0; fin = 0;
    while (!fin) begin
      if (restart && cyc == 3) begin
        start_i = 1'b1; addr_i = ~addr; op_i = ~op; mode_i = ~mode; exp_i = ~expd;
      end else begin
        start_i = 1'b0;
      end
      @(negedge clk);
      cyc++;
      if (done_o || err_o) fin = 1;
      else if (cyc > 2000) begin
        chk(0, {tag, " watchdog"}, cyc, 0);
        fin = 1;
      end
    end
    start_i = 1'b0;
    reads     = n_req - c_base;
    need      = mode ? b + 3 : b + 2;
    exp_done  = (need <= MAXP);
    exp_reads = exp_done ? need : MAXP;
    chk(done_o == exp_done, {tag, exp_done ? " R7 done" : " R9 no done"}, done_o, exp_done);
    chk(err_o == !exp_done, {tag, " R9 timeout err"}, err_o, !exp_done);
    chk(reads == exp_reads, {tag, " R7 read count"}, reads, exp_reads);
    chk(hs_d == 1'b1, {tag, " R7 pulse after response"}, hs_d, 1);
    chk(busy_o == 1'b0, {tag, " R10 idle with pulse"}, busy_o, 0);
    @(negedge clk);
    chk(!done_o && !err_o, {tag, " R10 single pulse"}, done_o | err_o, 0);
    repeat (3) @(negedge clk);
    chk(!rd_req_valid && n_req - c_base == reads, {tag, " R9 no more reads"},
        n_req - c_base, reads);
    chk(addr_bad == abase, {tag, " R3 address"}, addr_bad - abase, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(busy_o == 0, "R1 busy in reset", busy_o, 0);
    chk(!done_o && !err_o, "R1 pulses in reset", done_o | err_o, 0);
    chk(!rd_req_valid && !rd_rsp_ready, "R1 port in reset", rd_req_valid | rd_rsp_ready, 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk(!rd_req_valid && n_req == 0, "R1 idle quiet", n_req, 0);

    for (int b = 0; b < 14; b++) begin
      run(1'b0, 1'b0, b, -1, DW'(b * 4369 + 128 * (b % 2)), AW'(b * 291 + 7), b[0], 0, "R4 program");
      run(1'b1, 1'b0, b, -1, DW'(b * 77), AW'(b * 613 + 3), ~b[0], 0, "R5 erase");
      run(1'b0, 1'b1, b, -1, DW'(b), AW'(b * 97 + 11), b[1], 0, "R6 toggle");
    end
    for (int g = 0; g < 4; g++) begin
      run(1'b0, 1'b0, 5, g, DW'(g * 200), AW'(g + 40), g[0], 0, "R8 program glitch");
      run(1'b1, 1'b0, 6, g, '0, AW'(g + 80), 1'b0, 0, "R8 erase glitch");
    end
    run(1'b0, 1'b0, 4, -1, 16'h0080, 16'h1234, 1'b1, 1, "R2 restart program");
    run(1'b1, 1'b1, 3, -1, 16'h0000, 16'h0456, 1'b0, 1, "R2 restart toggle");
    run(1'b1, 1'b0, 13, -1, 16'h0000, 16'h0789, 1'b1, 1, "R2 restart timeout");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("test done: total=%0d bad=%0d", total + 1, bad + 1);
    $finish;
  end

endmodule